// File: doc/BRIEF.md
# FFT Output Normalisation Shifter

The block brings each FFT result back to one common binary weighting before display, storage or transmission. During the transform every word carries a two-part exponent: a 5-bit two's complement global weighting value shared by the pass, and a 2-bit word tag for the individual result. The block combines the two into the word's exponent. It subtracts that exponent from a configurable universal exponent and applies the difference as an arithmetic right shift to the 16-bit two's complement data word.

The shift amount is 4 bits wide. Two cases bypass the normal difference. A global value below the trap threshold forces the largest shift. Differences outside the shifter's range are clamped.

An optional pairing mode lets the real and imaginary parts of one complex result share the shifter on consecutive valid words. The real word sets the shift and the imaginary word reuses it. A valid flag travels with the data through one register stage.

Top module: `fft_out_normalizer`

## Requirements
- R1: With `raw_tag_mode` low, the tag weights the word's exponent as 00 = -1, 01 = 0, 10 = +1, 11 = +2. The exponent is the 5-bit two's complement `in_gw` plus that weight. The shift is the 6-bit two's complement `univ_exp` minus the exponent.
- R2: The data output is the 16-bit two's complement input arithmetically right-shifted by `out_shift`, with the sign bit copied into the vacated positions.
- R3: With `raw_tag_mode` high, the exponent is `in_gw` plus the unsigned tag value (0..3), and the universal exponent is taken as `univ_exp + 1`. Both modes give the same shift for the same inputs.
- R4: A computed shift above 15 is replaced by 15.
- R5: A computed shift below 0 is replaced by 0.
- R6: When `in_gw` is below the trap threshold (default -8), the shift is forced to 15 whatever the tag and universal exponent are. A value equal to the threshold is not trapped.
- R7: A word accepted with `in_valid` high appears on the outputs one clock later, with `out_valid` high for exactly that cycle.
- R8: In a cycle with `in_valid` low, `out_data`, `out_shift` and `out_imag` keep their values, whatever the data and exponent inputs are doing.
- R9: With `pair_mode` high, valid words alternate real then imaginary, starting with real. The imaginary word is shifted by the amount computed for the preceding real word, ignoring its own `in_gw` and `in_tag`, and is marked by `out_imag` high.
- R10: With `pair_mode` low, every valid word computes its own shift and `out_imag` stays low.
- R11: During reset, `out_valid`, `out_data`, `out_shift` and `out_imag` are all zero, and the pairing starts at the real word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_data | input | 16 | Two's complement data word |
| in_gw | input | 5 | Global weighting value, two's complement |
| in_tag | input | 2 | Word tag of the result |
| univ_exp | input | 6 | Universal target exponent, two's complement |
| raw_tag_mode | input | 1 | 1 selects the raw-tag exponent rule |
| pair_mode | input | 1 | 1 shares one shift across real/imaginary pairs |
| out_valid | output | 1 | Output word valid |
| out_data | output | 16 | Normalised data word |
| out_shift | output | 4 | Right shift applied to this word |
| out_imag | output | 1 | Word is the imaginary half of a pair |

## Verification
The internal state is the pairing phase and the held real shift. A wrong phase shows at the ports on the next valid word as a flipped `out_imag` and a shift taken from the wrong word's exponent. A corrupted held shift shows on the first imaginary output that follows. Errors in the exponent arithmetic appear one cycle after the offending input, on both `out_shift` and `out_data`. They are most visible at the trap boundary and where the difference crosses 0 or 15.

// File: rtl/norm_pkg.sv
package norm_pkg;

  // tag field width and the offset that centres tag 01 on weight zero
  localparam int TAG_W      = 2;
  localparam int TAG_CENTRE = 1;

  // selects how the exponent is assembled
  typedef enum logic {
    EXP_CENTRED = 1'b0,
    EXP_RAW     = 1'b1
  } exp_rule_e;

endpackage

// File: rtl/norm_shift_calc.sv
module norm_shift_calc
  import norm_pkg::*;
#(
  parameter int GW_W    = 5,
  parameter int UEXP_W  = 6,
  parameter int SHIFT_W = 4,
  parameter int TRAP_GW = -8
) (
  input  logic [GW_W-1:0]    gw_i,
  input  logic [TAG_W-1:0]   tag_i,
  input  logic [UEXP_W-1:0]  uexp_i,
  input  exp_rule_e          rule_i,
  output logic [SHIFT_W-1:0] shift_o
);

  localparam int CALC_W = ((UEXP_W > GW_W) ? UEXP_W : GW_W) + 3;
  localparam int MAX_SH = (1 << SHIFT_W) - 1;

  localparam logic signed [CALC_W-1:0] ONE_S  = CALC_W'(1);
  localparam logic signed [CALC_W-1:0] CTR_S  = CALC_W'(TAG_CENTRE);
  localparam logic signed [CALC_W-1:0] TRAP_S = CALC_W'(TRAP_GW);
  localparam logic signed [CALC_W-1:0] MAX_S  = CALC_W'(MAX_SH);
  localparam logic signed [CALC_W-1:0] ZERO_S = '0;

  logic signed [CALC_W-1:0] gw_s;
  logic signed [CALC_W-1:0] ue_s;
  logic signed [CALC_W-1:0] tag_s;
  logic signed [CALC_W-1:0] exp_s;
  logic signed [CALC_W-1:0] tgt_s;
  logic signed [CALC_W-1:0] diff_s;

  assign gw_s  = CALC_W'($signed(gw_i));
  assign ue_s  = CALC_W'($signed(uexp_i));
  assign tag_s = $signed({{(CALC_W-TAG_W){1'b0}}, tag_i});

  always_comb begin
    if (rule_i == EXP_RAW) begin
      exp_s = gw_s + tag_s;
      tgt_s = ue_s + ONE_S;
    end else begin
      exp_s = gw_s + tag_s - CTR_S;
      tgt_s = ue_s;
    end
    diff_s = tgt_s - exp_s;
  end

  always_comb begin
    if (gw_s < TRAP_S) begin
      shift_o = SHIFT_W'(MAX_SH);
    end else if (diff_s < ZERO_S) begin
      shift_o = '0;
    end else if (diff_s > MAX_S) begin
      shift_o = SHIFT_W'(MAX_SH);
    end else begin
      shift_o = diff_s[SHIFT_W-1:0];
    end
  end

endmodule

// File: rtl/norm_barrel.sv
module norm_barrel #(
  parameter int DATA_W  = 16,
  parameter int SHIFT_W = 4
) (
  input  logic [DATA_W-1:0]  data_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic [DATA_W-1:0]  data_o
);

  logic signed [DATA_W-1:0] stg [SHIFT_W+1];

  assign stg[0] = $signed(data_i);

  for (genvar k = 0; k < SHIFT_W; k++) begin : g_stage
    assign stg[k+1] = shift_i[k] ? (stg[k] >>> (1 << k)) : stg[k];
  end

  assign data_o = stg[SHIFT_W];

endmodule

// File: rtl/norm_pair_ctrl.sv
module norm_pair_ctrl #(
  parameter int SHIFT_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               valid_i,
  input  logic               pair_i,
  input  logic [SHIFT_W-1:0] calc_shift_i,
  output logic [SHIFT_W-1:0] use_shift_o,
  output logic               imag_o
);

  logic               phase_q, phase_n;
  logic [SHIFT_W-1:0] held_q,  held_n;

  assign imag_o      = pair_i & phase_q;
  assign use_shift_o = imag_o ? held_q : calc_shift_i;

  always_comb begin
    held_n  = held_q;
    phase_n = 1'b0;
    if (valid_i && !imag_o) begin
      held_n = calc_shift_i;
    end
    if (pair_i) begin
      phase_n = valid_i ? ~phase_q : phase_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      held_q  <= '0;
    end else begin
      phase_q <= phase_n;
      held_q  <= held_n;
    end
  end

endmodule

// File: rtl/fft_out_normalizer.sv
module fft_out_normalizer
  import norm_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int GW_W    = 5,
  parameter int UEXP_W  = 6,
  parameter int TRAP_GW = -8,
  localparam int SHIFT_W = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [DATA_W-1:0]  in_data,
  input  logic [GW_W-1:0]    in_gw,
  input  logic [TAG_W-1:0]   in_tag,
  input  logic [UEXP_W-1:0]  univ_exp,
  input  logic               raw_tag_mode,
  input  logic               pair_mode,
  output logic               out_valid,
  output logic [DATA_W-1:0]  out_data,
  output logic [SHIFT_W-1:0] out_shift,
  output logic               out_imag
);

  logic [SHIFT_W-1:0] calc_shift;
  logic [SHIFT_W-1:0] use_shift;
  logic               cur_imag;
  logic [DATA_W-1:0]  shifted;
  exp_rule_e          rule;

  logic               vld_q,   vld_n;
  logic [DATA_W-1:0]  data_q,  data_n;
  logic [SHIFT_W-1:0] shift_q, shift_n;
  logic               imag_q,  imag_n;

  assign rule = raw_tag_mode ? EXP_RAW : EXP_CENTRED;

  norm_shift_calc #(
    .GW_W    (GW_W),
    .UEXP_W  (UEXP_W),
    .SHIFT_W (SHIFT_W),
    .TRAP_GW (TRAP_GW)
  ) u_calc (
    .gw_i    (in_gw),
    .tag_i   (in_tag),
    .uexp_i  (univ_exp),
    .rule_i  (rule),
    .shift_o (calc_shift)
  );

  norm_pair_ctrl #(
    .SHIFT_W (SHIFT_W)
  ) u_pair (
    .clk          (clk),
    .rst_n        (rst_n),
    .valid_i      (in_valid),
    .pair_i       (pair_mode),
    .calc_shift_i (calc_shift),
    .use_shift_o  (use_shift),
    .imag_o       (cur_imag)
  );

  norm_barrel #(
    .DATA_W  (DATA_W),
    .SHIFT_W (SHIFT_W)
  ) u_barrel (
    .data_i  (in_data),
    .shift_i (use_shift),
    .data_o  (shifted)
  );

  always_comb begin
    vld_n   = in_valid;
    data_n  = data_q;
    shift_n = shift_q;
    imag_n  = imag_q;
    if (in_valid) begin
      data_n  = shifted;
      shift_n = use_shift;
      imag_n  = cur_imag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      data_q  <= '0;
      shift_q <= '0;
      imag_q  <= 1'b0;
    end else begin
      vld_q   <= vld_n;
      data_q  <= data_n;
      shift_q <= shift_n;
      imag_q  <= imag_n;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = data_q;
  assign out_shift = shift_q;
  assign out_imag  = imag_q;

endmodule

// File: rtl/norm_checker.sv
module norm_checker #(
  parameter int DATA_W  = 16,
  parameter int GW_W    = 5,
  parameter int SHIFT_W = 4,
  parameter int TRAP_GW = -8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [DATA_W-1:0]  in_data,
  input logic [GW_W-1:0]    in_gw,
  input logic               pair_mode,
  input logic               out_valid,
  input logic [DATA_W-1:0]  out_data,
  input logic [SHIFT_W-1:0] out_shift,
  input logic               out_imag
);

  logic [SHIFT_W-1:0] last_real;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_real <= '0;
    end else if (out_valid && !out_imag) begin
      last_real <= out_shift;
    end
  end

  // R7
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R7
  valid_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_data) && $stable(out_shift) && $stable(out_imag)));

  // R2
  sign_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_data[DATA_W-1] == $past(in_data[DATA_W-1])));

  // R6
  trap_forces_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !pair_mode && ($signed(in_gw) < TRAP_GW))
      |=> (out_shift == SHIFT_W'((1 << SHIFT_W) - 1)));

  // R9
  imag_reuses_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_imag) |-> (out_shift == last_real));

  // R10
  no_imag_unpaired_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !pair_mode) |=> !out_imag);

endmodule

bind fft_out_normalizer norm_checker #(
  .DATA_W  (DATA_W),
  .GW_W    (GW_W),
  .SHIFT_W (SHIFT_W),
  .TRAP_GW (TRAP_GW)
) u_norm_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .in_gw     (in_gw),
  .pair_mode (pair_mode),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_shift (out_shift),
  .out_imag  (out_imag)
);

// File: tb/test_fft_out_normalizer.sv
module test_fft_out_normalizer;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] in_data;
  logic [4:0]  in_gw;
  logic [1:0]  in_tag;
  logic [5:0]  univ_exp;
  logic        raw_tag_mode;
  logic        pair_mode;
  logic        out_valid;
  logic [15:0] out_data;
  logic [3:0]  out_shift;
  logic        out_imag;

  fft_out_normalizer i_fft_out_normalizer (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_data      (in_data),
    .in_gw        (in_gw),
    .in_tag       (in_tag),
    .univ_exp     (univ_exp),
    .raw_tag_mode (raw_tag_mode),
    .pair_mode    (pair_mode),
    .out_valid    (out_valid),
    .out_data     (out_data),
    .out_shift    (out_shift),
    .out_imag     (out_imag)
  );

  typedef struct {
    logic [15:0] data;
    logic [3:0]  shift;
    logic        imag;
    string       req;
  } exp_t;

  exp_t        sb_q[$];
  int          n_checks = 0;
  int          n_fail   = 0;
  logic        m_phase  = 1'b0;
  logic [3:0]  m_held   = '0;
  logic [15:0] last_data  = '0;
  logic [3:0]  last_shift = '0;
  logic        last_imag  = 1'b0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [3:0] model_shift(input logic [4:0] gw, input logic [1:0] tag,
                                             input logic [5:0] ue);
    int g, t, u, d;
    g = $signed(gw);
    t = int'(tag) - 1;
    u = $signed(ue);
    if (g < -8) return 4'd15;
    d = u - (g + t);
    if (d > 15) return 4'd15;
    if (d < 0)  return 4'd0;
    return d[3:0];
  endfunction

  task automatic check(input string req, input logic ok, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic send(input string req, input logic [15:0] d, input logic [4:0] gw,
                      input logic [1:0] tag, input logic [5:0] ue, input logic raw);
    exp_t e;
    logic [3:0] s;
    @(negedge clk);
    in_valid     = 1'b1;
    in_data      = d;
    in_gw        = gw;
    in_tag       = tag;
    univ_exp     = ue;
    raw_tag_mode = raw;
    if (pair_mode && m_phase) begin
      s = m_held;
      e.imag = 1'b1;
    end else begin
      s = model_shift(gw, tag, ue);
      m_held = s;
      e.imag = 1'b0;
    end
    if (pair_mode) m_phase = ~m_phase;
    else           m_phase = 1'b0;
    e.shift = s;
    e.data  = 16'($signed(d) >>> s);
    e.req   = req;
    sb_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = 16'($urandom);
      in_gw    = 5'($urandom);
      in_tag   = 2'($urandom);
      univ_exp = 6'($urandom);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (sb_q.size() == 0) begin
          check("R7", 1'b0, 1, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check({e.req, " shift"}, out_shift == e.shift, out_shift, e.shift);
          check({e.req, " data"},  out_data  == e.data,  out_data,  e.data);
          check({e.req, " imag"},  out_imag  == e.imag,  out_imag,  e.imag);
        end
        last_data  = out_data;
        last_shift = out_shift;
        last_imag  = out_imag;
      end else begin
        // R8: idle cycle keeps the last result
        check("R8 hold", (out_data == last_data) && (out_shift == last_shift)
              && (out_imag == last_imag), out_data, last_data);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0; in_data = '0; in_gw = '0; in_tag = '0; univ_exp = '0;
    raw_tag_mode = 1'b0; pair_mode = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", {out_valid, out_data, out_shift, out_imag} == '0,
          {out_valid, out_data, out_shift, out_imag}, 0);
    rst_n = 1'b1;

    // R1 / R2: each tag weight, positive and negative data
    send("R1", 16'h7FF0, 5'd2,  2'b00, 6'd4, 1'b0);
    send("R1", 16'h8123, 5'd2,  2'b01, 6'd4, 1'b0);
    send("R1", 16'h4000, 5'd2,  2'b10, 6'd4, 1'b0);
    send("R2", 16'hC000, 5'd0,  2'b11, 6'd7, 1'b0);
    send("R2", 16'hFFFF, 5'd1,  2'b01, 6'd9, 1'b0);
    idle(2);
    // R3: raw-tag rule gives the same shift
    send("R3", 16'h7FF0, 5'd2,  2'b00, 6'd4, 1'b1);
    send("R3", 16'h8123, 5'd2,  2'b01, 6'd4, 1'b1);
    send("R3", 16'hC000, 5'd0,  2'b11, 6'd7, 1'b1);
    send("R3", 16'h1234, 5'h1E, 2'b10, 6'd3, 1'b1);
    // R4: large positive difference saturates
    send("R4", 16'h8000, 5'h1B, 2'b00, 6'd31, 1'b0);
    send("R4", 16'h7FFF, 5'd0,  2'b01, 6'd16, 1'b0);
    // R5: negative difference clamps to zero
    send("R5", 16'hA5A5, 5'd5,  2'b11, 6'h36, 1'b0);
    send("R5", 16'h1234, 5'd3,  2'b01, 6'd2,  1'b1);
    // R6: trap boundary
    send("R6", 16'h8000, 5'h18, 2'b01, 6'h3C, 1'b0);
    send("R6", 16'h8000, 5'h17, 2'b01, 6'h3C, 1'b0);
    send("R6", 16'h7FFF, 5'h10, 2'b11, 6'h20, 1'b1);
    idle(3);
    // R7: isolated single word
    send("R7", 16'h0F00, 5'd0, 2'b01, 6'd4, 1'b0);
    idle(4);
    // R9: pairs, imaginary words carry different exponents
    @(negedge clk); pair_mode = 1'b1; in_valid = 1'b0;
    send("R9", 16'h4000, 5'd0,  2'b01, 6'd3, 1'b0);
    send("R9", 16'h8000, 5'd7,  2'b11, 6'd0, 1'b0);
    idle(2);
    send("R9", 16'h1000, 5'h1C, 2'b00, 6'd0, 1'b0);
    idle(1);
    send("R9", 16'hF000, 5'd0,  2'b01, 6'd0, 1'b0);
    send("R9", 16'h7000, 5'h10, 2'b10, 6'd1, 1'b1);
    send("R9", 16'h9000, 5'd3,  2'b00, 6'd1, 1'b1);
    idle(2);
    // R10: unpaired words each use their own exponent
    @(negedge clk); pair_mode = 1'b0; in_valid = 1'b0;
    send("R10", 16'h4000, 5'd0,  2'b01, 6'd3, 1'b0);
    send("R10", 16'h8000, 5'd7,  2'b11, 6'd0, 1'b0);
    send("R10", 16'h2468, 5'd1,  2'b10, 6'd6, 1'b0);
    idle(4);
    check("R7 drained", sb_q.size() == 0, sb_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule